// File: doc/BRIEF.md
# Stereo PCM Output Serializer

This block sends one 16-bit left sample and one 16-bit right sample per audio frame over a serial PCM link. A frame has 32 bit periods, so a 48 kHz frame rate needs a 1.536 MHz bit clock. Each frame is marked by a frame sync that is high for exactly one bit period. The left word follows the sync, then the right word, each sent most significant bit first. The serial data input of the port is not used in this direction.

In master mode the block makes the bit clock and the frame sync itself, by dividing the system clock. In slave mode it takes an external bit clock and frame sync, samples them in the system clock domain and follows their edges. A one-cycle strobe on the parallel side writes a left/right pair into a holding register. The pair is taken at the next frame boundary. If no new pair has arrived by then, the previous pair is sent again and the underrun output is raised for that frame.

Top module: `pcm_stereo_tx`

## Requirements
- R1: In master mode `bclk_out` is a square wave. It is high for HALF_DIV system clocks and low for HALF_DIV system clocks, and it starts low after reset.
- R2: In master mode `fsync_out` goes high on a rising bit-clock edge, stays high for exactly one bit period, and repeats every 32 bit periods. The first pulse starts on the first rising edge after reset.
- R3: On the rising edge after the sync pulse, `ser_out` carries left bit 15. The following rising edges carry left bits 14 down to 0, then right bits 15 down to 0. The last right bit is sent during the sync bit period. `ser_out` changes only after a rising bit-clock edge.
- R4: A pair is written on a cycle when `pair_valid` is 1, and a later write replaces an earlier one. The pair is taken for a frame at that frame's first rising edge. A write in that same cycle is kept for the following frame.
- R5: If no pair was written since the last frame boundary, the previous pair is sent again and `underrun` is 1 for that frame. Before any pair is taken, the previous pair is all zeros. `underrun` goes back to 0 at the first frame boundary that takes a new pair.
- R6: In slave mode `bclk_out` and `fsync_out` stay at 0. The block samples `ext_fsync` on the falling edges of `ext_bclk` and starts the left word on the rising `ext_bclk` edge that follows a sample of 1. In that mode the last right bit is sent during the sync bit period.
- R7: In slave mode `ser_out` is 0 until the first frame sync has been seen, even when a pair has already been written.
- R8: `ser_in` has no effect on any output.
- R9: While `rst_n` is low on a clock edge, `bclk_out`, `fsync_out`, `ser_out` and `underrun` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_mode | input | 1 | 1: generate bit clock and sync; 0: follow external ones (change only during reset) |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fsync | input | 1 | External frame sync (slave mode) |
| ser_in | input | 1 | Serial data input, ignored |
| pair_valid | input | 1 | Writes `left_in` and `right_in` into the holding register |
| left_in | input | 16 | Left sample, two's complement |
| right_in | input | 16 | Right sample, two's complement |
| bclk_out | output | 1 | Generated bit clock (0 in slave mode) |
| fsync_out | output | 1 | Generated frame sync (0 in slave mode) |
| ser_out | output | 1 | Serial audio data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
Some properties are checked on every cycle:
- the generated clock holds its level between divider wraps;
- the sync changes only on a rising edge and lasts one bit period;
- a master frame starts only under a sync;
- the serial output moves only after a rising edge;
- the slave output stays quiet before lock;
- the slave-mode clock outputs stay silent;
- a change on the serial input never moves the output;
- an underrun or a fresh pair sets the flag correctly.

Two things can only be shown by the bench's scenarios. The first is the exact bit order of a frame. The second is which pair lands in which frame: this covers overwritten pairs, a pair written in the boundary cycle and repeated frames. The bench runs a reference model in master mode and a bit-level external clock source in slave mode.

// File: rtl/pcm_tx_pkg.sv
// Package: shared sample and pair types for the stereo PCM serializer.
// Assumes two's complement samples of a fixed width on both channels.
package pcm_tx_pkg;
    localparam int PCM_SAMPLE_W = 16;

    typedef logic [PCM_SAMPLE_W-1:0] pcm_sample_t;

    typedef struct packed {
        pcm_sample_t left;
        pcm_sample_t right;
    } pcm_pair_t;
endpackage

// File: rtl/pcm_bclk_gen.sv
// Module: master bit-clock divider.
// Toggles the bit clock every HALF_DIV system clocks while enabled.
// Reports, one cycle ahead as a comb strobe, the edge at which the clock
// rises or falls. Assumes HALF_DIV >= 1. Held low when disabled.
module pcm_bclk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          bclk_q;
    logic          wrap;

    // Purpose: flag the cycle in which the divider wraps and the clock toggles.
    always_comb begin
        wrap = en && (cnt_q == LAST_C);
        rise = wrap && !bclk_q;
        fall = wrap && bclk_q;
    end

    // Purpose: count system clocks and toggle the bit clock on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign bclk = bclk_q;

    AST_BCLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q != '0) |-> $stable(bclk_q)); // R1
endmodule

// File: rtl/pcm_slave_edges.sv
// Module: synchronizer and edge detector for the external clock and sync.
// Assumes the external bit clock is much slower than the system clock:
// at least four system clocks per half period.
module pcm_slave_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_bclk,
    input  logic ext_fsync,
    output logic rise,
    output logic fall,
    output logic sync_at_fall
);
    logic [2:0] bclk_sh_q;
    logic [1:0] sync_sh_q;

    // Purpose: double-register the external pins and keep one extra clock stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sh_q <= '0;
            sync_sh_q <= '0;
        end else begin
            bclk_sh_q <= {bclk_sh_q[1:0], ext_bclk};
            sync_sh_q <= {sync_sh_q[0], ext_fsync};
        end
    end

    // Purpose: decode edges from the two oldest bit-clock stages.
    always_comb begin
        rise         = bclk_sh_q[1] && !bclk_sh_q[2];
        fall         = !bclk_sh_q[1] && bclk_sh_q[2];
        sync_at_fall = sync_sh_q[1];
    end
endmodule

// File: rtl/pcm_frame_ctrl.sv
// Module: frame sequencing.
// In master mode it counts bit periods and drives a one-bit sync before
// each frame. In slave mode it arms on a sync sampled at a falling edge and
// starts the frame at the next rising edge. It issues load and shift strobes
// to the shifter. Assumes rise and fall strobes are never both high.
module pcm_frame_ctrl #(
    parameter int FRAME_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic rise,
    input  logic fall,
    input  logic sync_at_fall,
    output logic load,
    output logic shift,
    output logic fsync,
    output logic locked
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_C = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] PRE_C  = CW'(FRAME_BITS - 2);

    logic [CW-1:0] bitcnt_q;
    logic [CW-1:0] bitcnt_nx;
    logic          fsync_q;
    logic          armed_q;
    logic          locked_q;

    // Purpose: pick frame start versus plain shift for this rising edge.
    always_comb begin
        bitcnt_nx = (bitcnt_q == LAST_C) ? '0 : bitcnt_q + 1'b1;
        load      = rise && (master ? (bitcnt_q == LAST_C) : armed_q);
        shift     = rise && !load;
    end

    // Purpose: master bit position, preset so the first rise issues the sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q <= PRE_C;
        end else if (master && rise) begin
            bitcnt_q <= bitcnt_nx;
        end
    end

    // Purpose: master sync, high during the last bit period of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !master) begin
            fsync_q <= 1'b0;
        end else if (rise) begin
            fsync_q <= (bitcnt_nx == LAST_C);
        end
    end

    // Purpose: slave arming on a sync seen at a falling edge, and first-lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || master) begin
            armed_q  <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            if (fall && sync_at_fall) begin
                armed_q <= 1'b1;
            end else if (load) begin
                armed_q <= 1'b0;
            end
            if (load) begin
                locked_q <= 1'b1;
            end
        end
    end

    assign fsync  = fsync_q;
    assign locked = locked_q;

    AST_FSYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (master && fsync_q && rise) |=> !fsync_q); // R2
    AST_FSYNC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_q) |-> $past(rise)); // R2
    AST_FRAME_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (master && load) |-> fsync_q); // R3
endmodule

// File: rtl/pcm_pair_shifter.sv
// Module: sample holding register and the 32-bit output shift register.
// Takes the held pair on load, or repeats the current pair and flags an
// underrun. Shifts MSB first on each shift strobe.
// Assumes load and shift are never both high.
module pcm_pair_shifter
    import pcm_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pair_valid,
    input  pcm_sample_t left_in,
    input  pcm_sample_t right_in,
    input  logic        load,
    input  logic        shift,
    output logic        ser_out,
    output logic        underrun
);
    localparam int FW = 2 * PCM_SAMPLE_W;

    pcm_pair_t      hold_q;
    logic           hold_full_q;
    pcm_pair_t      cur_q;
    logic [FW-1:0]  shreg_q;
    logic           under_q;

    // Purpose: keep the newest written pair until a frame boundary takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (pair_valid) begin
            hold_q      <= '{left: left_in, right: right_in};
            hold_full_q <= 1'b1;
        end else if (load) begin
            hold_full_q <= 1'b0;
        end
    end

    // Purpose: load the frame word at a boundary, else shift MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            shreg_q <= '0;
            under_q <= 1'b0;
        end else if (load) begin
            if (hold_full_q) begin
                cur_q   <= hold_q;
                shreg_q <= hold_q;
                under_q <= 1'b0;
            end else begin
                shreg_q <= cur_q;
                under_q <= 1'b1;
            end
        end else if (shift) begin
            shreg_q <= {shreg_q[FW-2:0], 1'b0};
        end
    end

    assign ser_out  = shreg_q[FW-1];
    assign underrun = under_q;

    AST_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R3
    AST_UNDERRUN_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !hold_full_q) |=> (under_q && shreg_q == cur_q)); // R5
    AST_FRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && hold_full_q) |=> !under_q); // R5
endmodule

// File: rtl/pcm_stereo_tx.sv
// Module: top of the stereo PCM output serializer.
// Selects generated or external timing, sequences 32-bit frames and
// serializes one left/right pair per frame. ser_in is accepted only so the
// port is complete; it drives nothing. master_mode is expected to change only
// while rst_n is low.
module pcm_stereo_tx
    import pcm_tx_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    master_mode,
    input  logic                    ext_bclk,
    input  logic                    ext_fsync,
    input  logic                    ser_in,
    input  logic                    pair_valid,
    input  logic [PCM_SAMPLE_W-1:0] left_in,
    input  logic [PCM_SAMPLE_W-1:0] right_in,
    output logic                    bclk_out,
    output logic                    fsync_out,
    output logic                    ser_out,
    output logic                    underrun
);
    localparam int FRAME_BITS = 2 * PCM_SAMPLE_W;

    logic gen_bclk, gen_rise, gen_fall;
    logic ext_rise, ext_fall, ext_sync;
    logic rise_sel, fall_sel;
    logic load, shift, fsync_int, locked;

    pcm_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
        .clk(clk), .rst_n(rst_n), .en(master_mode),
        .bclk(gen_bclk), .rise(gen_rise), .fall(gen_fall)
    );

    pcm_slave_edges u_edges (
        .clk(clk), .rst_n(rst_n), .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
        .rise(ext_rise), .fall(ext_fall), .sync_at_fall(ext_sync)
    );

    // Purpose: route the timing source selected by the mode pin.
    always_comb begin
        rise_sel = master_mode ? gen_rise : ext_rise;
        fall_sel = master_mode ? gen_fall : ext_fall;
    end

    pcm_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .master(master_mode),
        .rise(rise_sel), .fall(fall_sel), .sync_at_fall(ext_sync),
        .load(load), .shift(shift), .fsync(fsync_int), .locked(locked)
    );

    pcm_pair_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .left_in(left_in), .right_in(right_in),
        .load(load), .shift(shift), .ser_out(ser_out), .underrun(underrun)
    );

    assign bclk_out  = master_mode ? gen_bclk : 1'b0;
    assign fsync_out = fsync_int;

    AST_SLAVE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!bclk_out && !fsync_out)); // R6
    AST_QUIET_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !locked) |-> !ser_out); // R7
    AST_SER_IN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_sel && !$stable(ser_in)) |=> $stable(ser_out)); // R8
    AST_OUT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_out) |-> $past(rise_sel)); // R3
endmodule

// File: tb/test_pcm_stereo_tx.sv
`timescale 1ns/1ps
module test_pcm_stereo_tx;
    localparam int H  = 4;   // system clocks per bit-clock half period (master)
    localparam int SH = 8;   // system clocks per external half period (slave)

    logic clk = 1'b0;
    logic rst_n, master_mode, ext_bclk, ext_fsync, ser_in, pair_valid;
    logic [15:0] left_in, right_in;
    logic bclk_out, fsync_out, ser_out, underrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit chk_master = 1'b0;

    always #2 clk = ~clk;

    pcm_stereo_tx #(.HALF_DIV(H)) i_pcm_stereo_tx (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .ext_bclk(ext_bclk), .ext_fsync(ext_fsync), .ser_in(ser_in),
        .pair_valid(pair_valid), .left_in(left_in), .right_in(right_in),
        .bclk_out(bclk_out), .fsync_out(fsync_out), .ser_out(ser_out),
        .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model for master mode: time, rise count, frame word, pending pair
    int mt, mr, nr, pos;
    logic [31:0] mword, mcur, mpend;
    bit mpv, mund;

    always @(posedge clk) begin
        if (!rst_n || !master_mode) begin
            mt = 0; mr = 0; mword = 0; mcur = 0; mpend = 0; mpv = 0; mund = 0;
        end else begin
            mt++;
            nr = (mt / H + 1) / 2;
            if (nr != mr && nr >= 2 && (30 + nr) % 32 == 0) begin
                if (mpv) begin
                    mcur = mpend; mund = 0; mpv = 0;
                end else begin
                    mund = 1;
                end
                mword = mcur;
            end
            mr = nr;
            if (pair_valid) begin
                mpend = {left_in, right_in};
                mpv = 1;
            end
        end
    end

    // Cycle-by-cycle comparison against the model in master mode
    always @(negedge clk) begin
        if (chk_master && rst_n) begin
            check(bclk_out == ((mt / H) % 2), "R1", "bclk_out", bclk_out, (mt / H) % 2);
            check(fsync_out == (mr >= 1 && (30 + mr) % 32 == 31), "R2", "fsync_out",
                  fsync_out, (mr >= 1 && (30 + mr) % 32 == 31));
            pos = (30 + mr) % 32;
            check(ser_out == ((mr >= 2) ? mword[31 - pos] : 1'b0), "R3/R4", "ser_out",
                  ser_out, (mr >= 2) ? mword[31 - pos] : 1'b0);
            check(underrun == mund, "R5", "underrun", underrun, mund);
        end
    end

    task automatic put_pair(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        pair_valid = 1'b1; left_in = l; right_in = r;
        @(negedge clk);
        pair_valid = 1'b0;
    endtask

    // One external bit period: rise with the given sync level, check ser_out
    // late in the high half, then fall.
    task automatic sbit(input bit fs, input bit exp, input string req);
        @(negedge clk);
        ext_bclk = 1'b1; ext_fsync = fs; ser_in = ~ser_in;
        repeat (SH - 1) @(negedge clk);
        check(ser_out == exp, req, "slave ser_out", ser_out, exp);
        check(!bclk_out && !fsync_out, "R6", "slave clock pins", {bclk_out, fsync_out}, 0);
        @(negedge clk);
        ext_bclk = 1'b0;
        ser_in = ~ser_in;
        repeat (SH - 1) @(negedge clk);
    endtask

    logic [31:0] sw [4];
    bit          su [4];

    initial begin
        rst_n = 1'b0; master_mode = 1'b1; ext_bclk = 1'b0; ext_fsync = 1'b0;
        ser_in = 1'b0; pair_valid = 1'b0; left_in = '0; right_in = '0;
        repeat (3) @(negedge clk);
        check({bclk_out, fsync_out, ser_out, underrun} == 4'b0, "R9", "reset outputs",
              {bclk_out, fsync_out, ser_out, underrun}, 0);
        rst_n = 1'b1;
        chk_master = 1'b1;
        // Master run: pairs written at chosen model times (effective at mt+1)
        while (mt < 1700) begin
            @(negedge clk);
            pair_valid = 1'b0;
            ser_in = mt[0];   // R8: toggling input must not disturb the model match
            case (mt)
                3:    begin pair_valid = 1'b1; left_in = 16'hA5C3; right_in = 16'h0F71; end // frame 0
                150:  begin pair_valid = 1'b1; left_in = 16'h8001; right_in = 16'h7FFE; end // frame 1
                600:  begin pair_valid = 1'b1; left_in = 16'h1234; right_in = 16'h5678; end // overwritten
                700:  begin pair_valid = 1'b1; left_in = 16'hFFFF; right_in = 16'h0000; end // frame 3
                1035: begin pair_valid = 1'b1; left_in = 16'h3C96; right_in = 16'hC369; end // in boundary cycle: frame 5
                default: ;
            endcase
        end
        @(negedge clk);
        pair_valid = 1'b0;
        chk_master = 1'b0;

        // Slave run
        rst_n = 1'b0; master_mode = 1'b0;
        repeat (3) @(negedge clk);
        check({bclk_out, fsync_out, ser_out, underrun} == 4'b0, "R9", "slave reset outputs",
              {bclk_out, fsync_out, ser_out, underrun}, 0);
        rst_n = 1'b1;
        put_pair(16'hC0DE, 16'h1357);
        for (int i = 0; i < 4; i++) sbit(1'b0, 1'b0, "R7");
        sbit(1'b1, 1'b0, "R7");
        sw[0] = 32'hC0DE_1357; su[0] = 1'b0;
        sw[1] = 32'h6A6A_9595; su[1] = 1'b0;
        sw[2] = 32'h6A6A_9595; su[2] = 1'b1;
        sw[3] = 32'h0001_8000; su[3] = 1'b0;
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 32; i++) begin
                sbit(i == 31, sw[f][31 - i], "R6");
                if (i == 5)
                    check(underrun == su[f], "R5", "slave underrun", underrun, su[f]);
                if (f == 0 && i == 10) put_pair(16'h6A6A, 16'h9595);
                if (f == 2 && i == 20) put_pair(16'h0001, 16'h8000);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(50000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule